// File: doc/BRIEF.md
# Key-Serviced Watchdog Timer

This block guards a microcontroller against runaway software. It counts system clock cycles, either directly or through a fixed power-of-two prescaler, and when the selected period runs out without a valid service it raises a reset request for one clock and sets a sticky flag. The flag tells boot code that the last reset came from the watchdog.

Software sets the watchdog up with a single write to a control register. That write picks the enable, the prescaler bypass and one of four timeout exponents. The control register then locks, so running code cannot turn the watchdog off or loosen it. To keep the watchdog from firing, software writes an arming key of 0x55 and then a restart key of 0xAA to a separate service register. Other values may be written between the two keys.

Both registers sit behind one write strobe. A select input picks between them, and the write data is one byte.

Top module: `wdog_top`

## Requirements
- R1: After `rst_n` is released, `rst_req` and `wd_flag` are 0, the watchdog is disabled and the control register is unlocked. With no control write, `rst_req` stays 0.
- R2: A write with `wr_sel`=0 loads the control register: bit 0 is enable, bit 1 is prescaler bypass and bits 3:2 are the timeout code. The first such write after reset locks the register, and every later control write is ignored.
- R3: While enable is 0 the counter holds and `rst_req` is never asserted.
- R4: With bypass set, the period P is 2^E system clocks, where E is EXP0..EXP3 for timeout codes 0..3 (defaults 9, 11, 13 and 15, so code 3 gives 2^15). The reset request is registered at the clock edge P cycles after the enabling control write edge.
- R5: With bypass clear, the counter advances once every 2^PRE_LOG2 clocks (default 8), so P = 2^E * 2^PRE_LOG2.
- R6: A service write (`wr_sel`=1) of 0x55 arms the sequence. A service write of 0xAA while armed restarts the count and disarms the sequence, so the next request comes P cycles after the 0xAA write edge. Service writes of any other value leave the armed state unchanged.
- R7: A service write of 0xAA while not armed is ignored, and the expiry time is unchanged.
- R8: `rst_req` is high for exactly one clock per expiry. The count then restarts from zero, so unserviced expiries repeat every P cycles.
- R9: `wd_flag` is set at the first expiry and stays set until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the service register |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | One-clock reset request on expiry |
| wd_flag | output | 1 | Sticky flag: the watchdog has expired since reset |

## Verification
The bench measures the exact number of cycles from the enabling write, or from a restart key, to the request for every timeout code, with and without the prescaler. An off-by-one in the compare or the prescaler shows up as a period one tick too long or too short.

It also checks the service sequence in several ways:
- Random unrelated bytes are placed between the keys. A design that disarms on them would miss the restart and fire early.
- A lone 0xAA is written without the arming key. A design that accepts it would fire late.
- Control writes are repeated after the first one, including an attempt to disable. A design without the lock would stop firing or change period.
- The watchdog is left disabled for a long stretch, and a design that keeps counting would raise a request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic [1:0] sel;
    logic       byp;
    logic       en;
  } wdog_ctrl_t;

  localparam logic [7:0] KEY_ARM     = 8'h55;
  localparam logic [7:0] KEY_RESTART = 8'hAA;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_data,
  output wdog_ctrl_t ctrl
);
  wdog_ctrl_t ctrl_q, ctrl_d;
  logic       lock_q, lock_d;
  logic       load;

  assign load = ctl_wr && !lock_q;

  always_comb begin
    ctrl_d = ctrl_q;
    lock_d = lock_q;
    if (load) begin
      ctrl_d = wdog_ctrl_t'(ctl_data);
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      lock_q <= lock_d;
    end
  end

  assign ctrl = ctrl_q;

  // R2
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(ctrl_q));

  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       restart
);
  logic armed_q, armed_d;
  logic is_arm, is_rst;

  assign is_arm = svc_wr && (svc_data == KEY_ARM);
  assign is_rst = svc_wr && (svc_data == KEY_RESTART);

  always_comb begin
    armed_d = armed_q;
    if (is_arm)      armed_d = 1'b1;
    else if (is_rst) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign restart = is_rst && armed_q;

  // R6
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(svc_wr && svc_data == KEY_ARM));

  // R6
  disarm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed_q) |-> $past(restart));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int PRE_LOG2 = 3,
  parameter int EXP0     = 9,
  parameter int EXP1     = 11,
  parameter int EXP2     = 13,
  parameter int EXP3     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  wdog_ctrl_t ctrl,
  input  logic       restart,
  output logic       rst_req,
  output logic       wd_flag
);
  localparam int M01   = (EXP0 > EXP1) ? EXP0 : EXP1;
  localparam int M23   = (EXP2 > EXP3) ? EXP2 : EXP3;
  localparam int CNT_W = (M01 > M23) ? M01 : M23;

  logic [PRE_LOG2-1:0] pre_q, pre_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d, lim;
  logic                req_q, req_d, flag_q, flag_d;
  logic                tick, expire;

  always_comb begin
    case (ctrl.sel)
      2'd0:    lim = CNT_W'((64'd1 << EXP0) - 64'd1);
      2'd1:    lim = CNT_W'((64'd1 << EXP1) - 64'd1);
      2'd2:    lim = CNT_W'((64'd1 << EXP2) - 64'd1);
      default: lim = CNT_W'((64'd1 << EXP3) - 64'd1);
    endcase
  end

  assign tick   = ctrl.byp || (pre_q == '1);
  assign expire = ctrl.en && !restart && tick && (cnt_q == lim);

  always_comb begin
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    req_d  = expire;
    flag_d = flag_q || expire;
    if (restart) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (ctrl.en) begin
      pre_d = pre_q + 1'b1;
      if (tick) cnt_d = (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      req_q  <= req_d;
      flag_q <= flag_d;
    end
  end

  assign rst_req = req_q;
  assign wd_flag = flag_q;

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> !rst_req);

  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !restart) |=> $stable(cnt_q));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && !rst_req));

  // R9
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wd_flag);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_flag |=> wd_flag);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int PRE_LOG2 = 3,
  parameter int EXP0     = 9,
  parameter int EXP1     = 11,
  parameter int EXP2     = 13,
  parameter int EXP3     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       rst_req,
  output logic       wd_flag
);
  wdog_ctrl_t ctrl;
  logic       restart;
  logic       ctl_wr, svc_wr;

  assign ctl_wr = wr_en && !wr_sel;
  assign svc_wr = wr_en &&  wr_sel;

  wdog_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_data (wr_data[3:0]),
    .ctrl     (ctrl)
  );

  wdog_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_wr   (svc_wr),
    .svc_data (wr_data),
    .restart  (restart)
  );

  wdog_counter #(
    .PRE_LOG2 (PRE_LOG2),
    .EXP0     (EXP0),
    .EXP1     (EXP1),
    .EXP2     (EXP2),
    .EXP3     (EXP3)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .restart (restart),
    .rst_req (rst_req),
    .wd_flag (wd_flag)
  );

  // R1
  idle_until_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_flag |-> !rst_req);
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rst_req, wd_flag;

  int          n_chk  = 0;
  int          n_fail = 0;
  int unsigned cyc    = 0;
  int unsigned seed_v;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_top i_wdog_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rst_req (rst_req),
    .wd_flag (wd_flag)
  );

  function automatic int unsigned period(input int sel, input bit byp);
    int e;
    case (sel)
      0: e = 9;
      1: e = 11;
      2: e = 13;
      default: e = 15;
    endcase
    return (32'd1 << e) * (byp ? 32'd1 : 32'd8);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_req(input int unsigned lim, output int unsigned at);
    int unsigned n;
    n = 0;
    at = 0;
    while (!rst_req && n < lim) begin
      @(negedge clk);
      n++;
    end
    at = rst_req ? cyc : 32'hFFFF_FFFF;
  endtask

  task automatic measure(input string req, input int unsigned t0, input int unsigned p);
    int unsigned at;
    wait_req(p + 64, at);
    check(req, longint'(at) - longint'(t0), p);
  endtask

  task automatic quiet(input string req, input int unsigned n);
    int hits;
    hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (rst_req) hits++;
    end
    check(req, hits, 0);
  endtask

  function automatic logic [7:0] junk();
    logic [7:0] v;
    v = 8'($urandom);
    while (v == 8'hAA) v = 8'($urandom);
    return v;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned t0, at;
    seed_v = $urandom(32'd2718);
    do_reset();
    // R1 reset state and no request without configuration
    check("R1 rst_req", rst_req, 0);
    check("R1 flag", wd_flag, 0);
    quiet("R1 unconfigured", 2000);

    // R4 bypass periods for each code, R8 pulse/repeat, R9 flag
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(1'b0, {4'h0, 2'(s), 1'b1, 1'b1});
      t0 = cyc;
      measure("R4 bypass period", t0, period(s, 1'b1));
      t0 = cyc;
      check("R9 flag set", wd_flag, 1);
      @(negedge clk);
      check("R8 one-clock pulse", rst_req, 0);
      if (s == 0) begin
        measure("R8 repeat period", t0, period(s, 1'b1));
        @(negedge clk);
        check("R9 flag sticky", wd_flag, 1);
      end
    end

    // R5 prescaled period
    do_reset();
    wr(1'b0, 8'h01);
    t0 = cyc;
    measure("R5 prescaled period", t0, period(0, 1'b0));

    // R6 service with random filler between keys
    do_reset();
    wr(1'b0, 8'h03);
    for (int k = 0; k < 6; k++) begin
      repeat ($urandom_range(10, 300)) @(negedge clk);
      wr(1'b1, 8'h55);
      for (int j = 0; j < int'($urandom_range(0, 5)); j++) wr(1'b1, junk());
      wr(1'b1, 8'hAA);
      t0 = cyc;
      if (k == 5) measure("R6 restart after keys", t0, period(0, 1'b1));
      else begin
        check("R6 no early request", rst_req, 0);
        check("R9 flag clear while serviced", wd_flag, 0);
      end
    end

    // R7 lone restart key ignored
    do_reset();
    wr(1'b0, 8'h03);
    t0 = cyc;
    repeat (100) @(negedge clk);
    wr(1'b1, 8'hAA);
    wr(1'b1, junk());
    wr(1'b1, 8'hAA);
    measure("R7 unarmed key ignored", t0, period(0, 1'b1));

    // R3 disabled: holds; R2 lock prevents enabling later
    do_reset();
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h03);
    quiet("R3 disabled no request", 3000);
    check("R3 flag", wd_flag, 0);

    // R2 lock prevents disable or period change
    do_reset();
    wr(1'b0, 8'h03);
    t0 = cyc;
    wr(1'b0, 8'h0E);
    wr(1'b0, 8'h00);
    measure("R2 locked config", t0, period(0, 1'b1));

    // R9 flag cleared by reset
    do_reset();
    check("R9 flag cleared by reset", wd_flag, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule